// File: doc/BRIEF.md
# A/D Conversion Timing Sequencer

This block generates every timing strobe that a successive-approximation A/D converter needs, working from a fast system clock. A three-bit divider code sets how many system clocks make up one conversion-clock period. A two-bit mode code chooses a conversion length: 45 conversion clocks for fast conversions, or 54 for a lower-current setting. The first 13.5 conversion clocks of each conversion are the sampling window.

A conversion begins on a trigger pulse. When settling is enabled, the block first waits a programmable number of system clocks to let the analog supply settle. In continuous mode, conversions run back to back after the trigger. The settling wait comes only once, ahead of the first conversion of the run. Outputs are a one-cycle conversion-clock strobe, a sampling flag, a busy flag and a done pulse.

Configuration is loaded through a write strobe and is locked while the run-enable input is high. Dropping the run enable stops all activity on the next clock.

Top module: `adc_seq_timer`

## Requirements
- R1: Divider code to ratio R: 000=32, 001=16, 010=8, 011=4, 100=2, 101=1. During a conversion, `ck_en_o` is high in the last system clock of each R-cycle period, counted from the conversion's first cycle.
- R2: With mode code 00, a conversion lasts 45·R system clocks.
- R3: With mode code 01, a conversion lasts 54·R system clocks.
- R4: `sample_o` is high for the first ceil(13.5·R) system clocks of every conversion, which is 14 at R=1, and low otherwise.
- R5: `done_o` is a single-cycle pulse in the last cycle of each conversion. It coincides with a `ck_en_o` strobe.
- R6: With settling off, a trigger sampled in idle with run enable high starts a conversion in the next cycle. A trigger that arrives while busy has no effect.
- R7: With settling on, a trigger first gives SETTLE_CYCLES busy cycles with no strobe and no sampling. The conversion follows immediately after.
- R8: In continuous mode, a new conversion starts in the cycle after each done, with no settling. In single mode, the block returns to idle after done.
- R9: A configuration write (`cfg_we_i`) takes effect only when run enable is low and both codes are valid. Invalid codes are divider 110/111 and mode 1x. A rejected write leaves the previous configuration in place.
- R10: When `conv_en_i` is low, the block is idle with `busy_o` low from the next cycle on. Any pending settling or conversion is cancelled, and triggers are ignored.
- R11: After reset, all outputs are low and the configuration is divider 000, mode 00, settling off, single mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| conv_en_i | input | 1 | Run enable; locks the configuration while high |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_div_i | input | 3 | Divider code |
| cfg_mode_i | input | 2 | Mode code (00 fast, 01 low current) |
| cfg_settle_i | input | 1 | Insert settling wait after a trigger |
| cfg_cont_i | input | 1 | Continuous conversion mode |
| trig_i | input | 1 | Conversion trigger |
| ck_en_o | output | 1 | Conversion-clock strobe |
| sample_o | output | 1 | Sampling window flag |
| busy_o | output | 1 | Settling or converting |
| done_o | output | 1 | End-of-conversion pulse |

## Verification
The bench runs the fast and low-current lengths across the divide ratios /1, /2, /4, /8, /16 and /32. The /1 setting isolates the rounded sample window, and /32 probes the widest counter values. Single runs with and without settling separate the one-time wait from the start latency. A continuous run with settling shows whether the wait wrongly repeats before later conversions. Triggers sent while busy or disabled, writes sent while locked or with invalid codes, and a stop in the middle of a run each show whether state leaks across those events.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned DIV_W       = 3;
  localparam int unsigned MODE_W      = 2;
  localparam int unsigned DIV_LOG2MAX = 5;
  localparam int unsigned HS_CLKS     = 45;
  localparam int unsigned LC_CLKS     = 54;
  localparam int unsigned SAMPLE_HALF = 27;
  localparam int unsigned CNT_W       = $clog2(LC_CLKS << DIV_LOG2MAX);

  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_CONV} seq_state_e;

  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic [MODE_W-1:0] mode;
    logic              settle;
    logic              cont;
  } seq_cfg_t;

  function automatic logic cfg_legal(logic [DIV_W-1:0] div, logic [MODE_W-1:0] mode);
    return (int'(div) <= int'(DIV_LOG2MAX)) && !mode[1];
  endfunction
endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              we_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              settle_i,
  input  logic              cont_i,
  output seq_cfg_t          cfg_o
);
  logic accept;
  assign accept = we_i && !lock_i && cfg_legal(div_i, mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
    end else if (accept) begin
      cfg_o.div    <= div_i;
      cfg_o.mode   <= mode_i;
      cfg_o.settle <= settle_i;
      cfg_o.cont   <= cont_i;
    end
  end
endmodule

// File: rtl/adc_seq_timing.sv
module adc_seq_timing
  import adc_seq_pkg::*;
(
  input  logic [DIV_W-1:0]  div_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [CNT_W-1:0]  tick_mask_o,
  output logic [CNT_W-1:0]  conv_last_o,
  output logic [CNT_W-1:0]  samp_len_o
);
  logic [DIV_W-1:0] shift;
  logic [CNT_W-1:0] ratio, clks, half_sum;

  always_comb begin
    shift       = DIV_W'(DIV_LOG2MAX) - div_i;
    ratio       = CNT_W'(1) << shift;
    clks        = mode_i[0] ? CNT_W'(LC_CLKS) : CNT_W'(HS_CLKS);
    tick_mask_o = ratio - CNT_W'(1);
    conv_last_o = (clks << shift) - CNT_W'(1);
    // 13.5 conversion clocks, rounded up to whole system clocks
    half_sum    = (CNT_W'(SAMPLE_HALF) << shift) + CNT_W'(1);
    samp_len_o  = half_sum >> 1;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 250,
  localparam int unsigned SET_W = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             trig_i,
  input  logic             settle_i,
  input  logic             cont_i,
  input  logic [CNT_W-1:0] tick_mask_i,
  input  logic [CNT_W-1:0] conv_last_i,
  input  logic [CNT_W-1:0] samp_len_i,
  output logic             ck_en_o,
  output logic             sample_o,
  output logic             busy_o,
  output logic             done_o
);
  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SET_W-1:0] wait_q, wait_d;
  logic             conv, last;

  assign conv = (state_q == ST_CONV);
  assign last = conv && (cnt_q == conv_last_i);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wait_d  = wait_q;
    if (!en_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      wait_d  = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (trig_i) begin
          cnt_d = '0;
          if (settle_i) begin
            state_d = ST_SETTLE;
            wait_d  = SET_W'(SETTLE_CYCLES - 1);
          end else begin
            state_d = ST_CONV;
          end
        end
        ST_SETTLE: begin
          if (wait_q == '0) state_d = ST_CONV;
          else              wait_d  = wait_q - SET_W'(1);
        end
        ST_CONV: begin
          if (last) begin
            cnt_d = '0;
            if (!cont_i) state_d = ST_IDLE;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wait_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wait_q  <= wait_d;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign ck_en_o  = conv && ((cnt_q & tick_mask_i) == tick_mask_i);
  assign sample_o = conv && (cnt_q < samp_len_i);
  assign done_o   = last;
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
  import adc_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 250
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       conv_en_i,
  input  logic       cfg_we_i,
  input  logic [2:0] cfg_div_i,
  input  logic [1:0] cfg_mode_i,
  input  logic       cfg_settle_i,
  input  logic       cfg_cont_i,
  input  logic       trig_i,
  output logic       ck_en_o,
  output logic       sample_o,
  output logic       busy_o,
  output logic       done_o
);
  seq_cfg_t         cfg;
  logic [2:0]       div_q;
  logic [1:0]       mode_q;
  logic [CNT_W-1:0] tick_mask, conv_last, samp_len;

  assign div_q  = cfg.div;
  assign mode_q = cfg.mode;

  adc_seq_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lock_i  (conv_en_i),
    .we_i    (cfg_we_i),
    .div_i   (cfg_div_i),
    .mode_i  (cfg_mode_i),
    .settle_i(cfg_settle_i),
    .cont_i  (cfg_cont_i),
    .cfg_o   (cfg)
  );

  adc_seq_timing u_timing (
    .div_i      (cfg.div),
    .mode_i     (cfg.mode),
    .tick_mask_o(tick_mask),
    .conv_last_o(conv_last),
    .samp_len_o (samp_len)
  );

  adc_seq_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (conv_en_i),
    .trig_i     (trig_i),
    .settle_i   (cfg.settle),
    .cont_i     (cfg.cont),
    .tick_mask_i(tick_mask),
    .conv_last_i(conv_last),
    .samp_len_i (samp_len),
    .ck_en_o    (ck_en_o),
    .sample_o   (sample_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       conv_en_i,
  input logic       trig_i,
  input logic       ck_en_o,
  input logic       sample_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [2:0] div_q,
  input logic [1:0] mode_q
);
  AST_CFG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_en_i |=> ($stable(div_q) && $stable(mode_q))); // R9
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_en_i |=> !busy_o); // R10
  AST_SAMPLE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> busy_o); // R4
  AST_DONE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ck_en_o && busy_o)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_NO_SELF_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !trig_i) |=> !busy_o); // R6
  AST_TICK_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ck_en_o |-> busy_o); // R1
endmodule

bind adc_seq_timer adc_seq_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .conv_en_i(conv_en_i),
  .trig_i   (trig_i),
  .ck_en_o  (ck_en_o),
  .sample_o (sample_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .div_q    (div_q),
  .mode_q   (mode_q)
);

// File: tb/adc_seq_timer_bench.sv
module adc_seq_timer_bench;
  localparam int SETTLE = 250;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       conv_en_i = 1'b0, cfg_we_i = 1'b0, cfg_settle_i = 1'b0, cfg_cont_i = 1'b0, trig_i = 1'b0;
  logic [2:0] cfg_div_i = 3'd0;
  logic [1:0] cfg_mode_i = 2'd0;
  logic       ck_en_o, sample_o, busy_o, done_o;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 1'b0;

  // reference model state
  int m_ph = 0, m_cnt = 0, m_wait = 0;
  int m_div = 0, m_mode = 0, m_settle = 0, m_cont = 0;

  always #2 clk_i = ~clk_i;

  adc_seq_timer #(.SETTLE_CYCLES(SETTLE)) u_adc_seq_timer (
    .clk_i, .rst_ni, .conv_en_i, .cfg_we_i, .cfg_div_i, .cfg_mode_i,
    .cfg_settle_i, .cfg_cont_i, .trig_i, .ck_en_o, .sample_o, .busy_o, .done_o
  );

  function automatic int ratio_of(int d); return 32 >> d; endfunction
  function automatic int len_of(int d, int m); return (m == 1 ? 54 : 45) * ratio_of(d); endfunction
  function automatic int samp_of(int d); return (27 * ratio_of(d) + 1) / 2; endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_cnt = 0; m_wait = 0;
      m_div = 0; m_mode = 0; m_settle = 0; m_cont = 0;
    end else begin
      if (!conv_en_i) begin
        m_ph = 0; m_cnt = 0; m_wait = 0;
      end else if (m_ph == 0) begin
        if (trig_i) begin
          m_cnt = 0;
          if (m_settle != 0) begin m_ph = 1; m_wait = SETTLE - 1; end
          else m_ph = 2;
        end
      end else if (m_ph == 1) begin
        if (m_wait == 0) m_ph = 2; else m_wait--;
      end else begin
        if (m_cnt == len_of(m_div, m_mode) - 1) begin
          m_cnt = 0;
          if (m_cont == 0) m_ph = 0;
        end else m_cnt++;
      end
      if (cfg_we_i && !conv_en_i && cfg_div_i <= 3'd5 && cfg_mode_i <= 2'd1) begin
        m_div = cfg_div_i; m_mode = cfg_mode_i;
        m_settle = cfg_settle_i; m_cont = cfg_cont_i;
      end
    end
  end

  task automatic chk(input logic got, input logic exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: got %0b expected %0b", tag, cyc, got, exp);
    end
  endtask

  always @(negedge clk_i) if (!finished) begin
    int r;
    r = ratio_of(m_div);
    chk(busy_o,   m_ph != 0, "R6 R7 R8 R10 busy_o");
    chk(sample_o, m_ph == 2 && m_cnt < samp_of(m_div), "R4 sample_o");
    chk(ck_en_o,  m_ph == 2 && (m_cnt % r) == r - 1, "R1 ck_en_o");
    chk(done_o,   m_ph == 2 && m_cnt == len_of(m_div, m_mode) - 1, "R2 R3 R5 done_o");
  end

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic write_cfg(input int d, input int m, input bit s, input bit c);
    cfg_div_i = 3'(d); cfg_mode_i = 2'(m); cfg_settle_i = s; cfg_cont_i = c;
    cfg_we_i = 1'b1; step(); cfg_we_i = 1'b0;
  endtask

  task automatic pulse_trig();
    trig_i = 1'b1; step(); trig_i = 1'b0;
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 100000 && !finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    step(3);
    // R11: reset state of the outputs
    chk(busy_o | sample_o | ck_en_o | done_o, 1'b0, "R11 outputs in reset");
    rst_ni = 1'b1;
    step(2);
    // R11: default config is /32 fast single, no settle; trigger starts conversion
    conv_en_i = 1'b1; step(); pulse_trig(); step(20);
    conv_en_i = 1'b0; step(2);  // R10 stop mid-conversion

    // R1 R2 R4 R6: /1 fast single, trigger while busy ignored
    write_cfg(5, 0, 0, 0);
    conv_en_i = 1'b1; step(); pulse_trig(); step(10); pulse_trig(); step(50);

    // R9: locked write ignored, then invalid codes ignored
    write_cfg(0, 1, 1, 1);
    conv_en_i = 1'b0; step();
    write_cfg(6, 0, 0, 0);
    write_cfg(7, 1, 0, 0);
    write_cfg(2, 2, 0, 0);
    // R10: trigger while disabled ignored
    pulse_trig(); step(5);
    conv_en_i = 1'b1; step(); pulse_trig(); step(60);

    // R3: /2 low current single
    conv_en_i = 1'b0; write_cfg(4, 1, 0, 0);
    conv_en_i = 1'b1; step(); pulse_trig(); step(130);

    // R7: settle then /8 fast single; second trigger settles again
    conv_en_i = 1'b0; write_cfg(2, 0, 1, 0);
    conv_en_i = 1'b1; step(); pulse_trig(); step(640); pulse_trig(); step(100);
    // R10: stop during settling cancels it
    conv_en_i = 1'b0; step(3);
    conv_en_i = 1'b1; step(); pulse_trig(); step(100);
    conv_en_i = 1'b0; step(3);

    // R8: continuous /4 low current with settle once
    write_cfg(3, 1, 1, 1);
    conv_en_i = 1'b1; step(); pulse_trig(); step(1000);
    conv_en_i = 1'b0; step(3);

    // R8: continuous /1 without settle, R2 back to back
    write_cfg(5, 0, 0, 1);
    conv_en_i = 1'b1; step(); pulse_trig(); step(200);
    conv_en_i = 1'b0; step(3);

    // R2 R3: widest counts
    write_cfg(0, 0, 0, 0);
    conv_en_i = 1'b1; step(); pulse_trig(); step(1460);
    conv_en_i = 1'b0; write_cfg(1, 1, 0, 0);
    conv_en_i = 1'b1; step(); pulse_trig(); step(880);
    conv_en_i = 1'b0; step(3);
    summary();
  end
endmodule